// File: doc/BRIEF.md
# Address Window Decoder with Remap

The block routes a 32-bit address to one of eight programmable windows. Each window has four registers on a small word-addressed bus: a control word holding the window size, a 4-bit target ID, an 8-bit attribute and an enable bit, and a base address. The lower four windows also hold a low and a high remap word. A lookup request gives an address. One clock later the block returns a hit or a miss, the index of the winning window, its target ID and attribute, and the address as translated by that window.

The size field is a mask of ones that fills from the least significant bit, counted in 64 KB pages. Each extra one doubles the span: a mask of all zeros covers one page, and 0x00FF covers 256 pages (16 MB). The address bits under the mask pass through, and the bits above it are compared with the base. A remap-capable window puts the unmasked upper bits of its remap-low word in place of the unmasked address bits. Software that wants no translation writes remap-low equal to the base. All registers clear on reset, so every window starts disabled.

Top module: `awd_decoder`

## Requirements
- R1: After reset every register reads 0 and every lookup returns a miss.
- R2: Register address is {window[2:0], select[1:0]} with select 0 = control, 1 = base, 2 = remap-low, 3 = remap-high. A read returns the full 32-bit word on reg_rdata in the cycle after reg_rd. Control layout: bit 0 enable, bits 7:4 target, bits 15:8 attribute, bits 31:16 size mask.
- R3: Windows 4 to 7 have no remap storage. Writes to their select 2 and 3 are ignored, and reads of those selects return 0.
- R4: An enabled window matches when lk_addr[31:16] and base[31:16] agree on every bit where the size mask is 0. A mask of 0x0000 spans 64 KB and 0x00FF spans 16 MB.
- R5: A window whose enable bit is 0 never hits, whatever its size and base.
- R6: When several enabled windows match, the lowest-numbered one is reported.
- R7: On a miss, res_miss is 1, res_hit is 0, res_win, res_target, res_attr and res_addr_hi are 0, and res_addr equals the lookup address.
- R8: A hit on window 0 to 3 gives res_addr = {(remap_lo[31:16] & ~size) | (lk_addr[31:16] & size), lk_addr[15:0]} and res_addr_hi = remap-high of that window.
- R9: A hit on window 4 to 7 gives res_addr equal to the lookup address and res_addr_hi equal to 0.
- R10: res_valid is 1 exactly in the cycle after lk_valid. The result uses the register values that were in place before any write made in the lookup's own cycle.
- R11: While res_valid is 1, exactly one of res_hit and res_miss is 1. While it is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Window index and register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | 3 | Winning window index |
| res_target | output | 4 | Target ID of winning window |
| res_attr | output | 8 | Attribute of winning window |
| res_addr | output | 32 | Translated address |
| res_addr_hi | output | 32 | Upper remap word of winning window |

## Verification
Lookups land just inside and just outside window edges for a 64 KB window and a 16 MB window. These show whether the mask decides the span or the compare is off by a page. Addresses that fall under two overlapping windows, first with both enabled and then with the lower one disabled, show whether priority and the enable bit work. A disabled window that covers the whole space shows that enable gates every match. Lookups on remap-capable windows and on plain windows show whether translation applies only to the low four. A lookup issued in the same cycle as the write that enables its window shows whether the result uses the register values from before that write.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
package awd_pkg;
    localparam int AWD_DW     = 32;
    localparam int AWD_SZW    = 16;
    localparam int AWD_PGW    = AWD_DW - AWD_SZW;
    localparam int AWD_TGW    = 4;
    localparam int AWD_ATW    = 8;
    localparam int AWD_EN_BIT = 0;
    localparam int AWD_TG_LSB = 4;
    localparam int AWD_AT_LSB = 8;
    localparam int AWD_SZ_LSB = 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/awd_regfile.sv
`timescale 1ns/1ps
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NREMAP = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int RA_W  = WIN_W + 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr,
    input  logic                                  reg_rd,
    input  logic [RA_W-1:0]                       reg_addr,
    input  logic [AWD_DW-1:0]                     reg_wdata,
    output logic [AWD_DW-1:0]                     reg_rdata,
    output logic [NWIN-1:0]                       win_en,
    output logic [NWIN-1:0][AWD_TGW-1:0]          win_tgt,
    output logic [NWIN-1:0][AWD_ATW-1:0]          win_attr,
    output logic [NWIN-1:0][AWD_SZW-1:0]          win_size,
    output logic [NWIN-1:0][AWD_SZW-1:0]          win_base,
    output logic [NREMAP-1:0][AWD_SZW-1:0]        rmp_lo,
    output logic [NREMAP-1:0][AWD_DW-1:0]         rmp_hi
);
    logic [NWIN-1:0][AWD_DW-1:0] ctrl_v;
    logic [NWIN-1:0][AWD_DW-1:0] base_v;
    logic [NWIN-1:0][AWD_DW-1:0] rlo_v;
    logic [NWIN-1:0][AWD_DW-1:0] rhi_v;
    logic [WIN_W-1:0]            win_sel;
    reg_sel_e                    reg_sel;
    logic [AWD_DW-1:0]           rd_word;
    logic [AWD_DW-1:0]           rdata_q;

    assign win_sel = reg_addr[RA_W-1:2];
    assign reg_sel = reg_sel_e'(reg_addr[1:0]);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic              wr_here;
        logic [AWD_DW-1:0] ctrl_q;
        logic [AWD_DW-1:0] base_q;

        assign wr_here = reg_wr && (win_sel == WIN_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                base_q <= '0;
            end else if (wr_here) begin
                if (reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
                if (reg_sel == SEL_BASE) base_q <= reg_wdata;
            end
        end

        assign ctrl_v[w]   = ctrl_q;
        assign base_v[w]   = base_q;
        assign win_en[w]   = ctrl_q[AWD_EN_BIT];
        assign win_tgt[w]  = ctrl_q[AWD_TG_LSB +: AWD_TGW];
        assign win_attr[w] = ctrl_q[AWD_AT_LSB +: AWD_ATW];
        assign win_size[w] = ctrl_q[AWD_SZ_LSB +: AWD_SZW];
        assign win_base[w] = base_q[AWD_PGW +: AWD_SZW];

        if (w < NREMAP) begin : g_rmp
            logic [AWD_DW-1:0] rlo_q;
            logic [AWD_DW-1:0] rhi_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rlo_q <= '0;
                    rhi_q <= '0;
                end else if (wr_here) begin
                    if (reg_sel == SEL_RLO) rlo_q <= reg_wdata;
                    if (reg_sel == SEL_RHI) rhi_q <= reg_wdata;
                end
            end

            assign rlo_v[w]  = rlo_q;
            assign rhi_v[w]  = rhi_q;
            assign rmp_lo[w] = rlo_q[AWD_PGW +: AWD_SZW];
            assign rmp_hi[w] = rhi_q;
        end else begin : g_flat
            assign rlo_v[w] = '0;
            assign rhi_v[w] = '0;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(win_sel) < NWIN) begin
            unique case (reg_sel)
                SEL_CTRL: rd_word = ctrl_v[win_sel];
                SEL_BASE: rd_word = base_v[win_sel];
                SEL_RLO:  rd_word = rlo_v[win_sel];
                SEL_RHI:  rd_word = rhi_v[win_sel];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_word;
    end

    assign reg_rdata = rdata_q;

    // R3: remap selects of plain windows read back as zero
    assert_remap_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (int'(win_sel) >= NREMAP) && reg_addr[1]) |=> (reg_rdata == '0));
endmodule

// File: rtl/awd_match.sv
`timescale 1ns/1ps
module awd_match
    import awd_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [NWIN-1:0]              win_en,
    input  logic [NWIN-1:0][AWD_SZW-1:0] win_size,
    input  logic [NWIN-1:0][AWD_SZW-1:0] win_base,
    input  logic [AWD_SZW-1:0]           lk_page,
    output logic [NWIN-1:0]              match
);
    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [AWD_SZW-1:0] keep;
        assign keep     = ~win_size[w];
        assign match[w] = win_en[w] && ((lk_page & keep) == (win_base[w] & keep));
    end
endmodule

// File: rtl/awd_select.sv
`timescale 1ns/1ps
module awd_select
    import awd_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NREMAP = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NWIN-1:0]                match,
    input  logic [NWIN-1:0][AWD_TGW-1:0]   win_tgt,
    input  logic [NWIN-1:0][AWD_ATW-1:0]   win_attr,
    input  logic [NWIN-1:0][AWD_SZW-1:0]   win_size,
    input  logic [NREMAP-1:0][AWD_SZW-1:0] rmp_lo,
    input  logic [NREMAP-1:0][AWD_DW-1:0]  rmp_hi,
    input  logic [AWD_DW-1:0]              lk_addr,
    output logic                           sel_hit,
    output logic [WIN_W-1:0]               sel_win,
    output logic [AWD_TGW-1:0]             sel_tgt,
    output logic [AWD_ATW-1:0]             sel_attr,
    output logic [AWD_DW-1:0]              sel_addr,
    output logic [AWD_DW-1:0]              sel_addr_hi
);
    logic [NWIN-1:0]              grant;
    logic [NWIN-1:0][AWD_DW-1:0]  xl_addr;
    logic [NWIN-1:0][AWD_DW-1:0]  xl_hi;

    // isolate the lowest set bit: lowest window number wins
    assign grant = match & (~match + NWIN'(1));

    for (genvar w = 0; w < NWIN; w++) begin : g_xl
        if (w < NREMAP) begin : g_rmp
            assign xl_addr[w] = {(rmp_lo[w] & ~win_size[w]) |
                                 (lk_addr[AWD_PGW +: AWD_SZW] & win_size[w]),
                                 lk_addr[AWD_PGW-1:0]};
            assign xl_hi[w]   = rmp_hi[w];
        end else begin : g_flat
            assign xl_addr[w] = lk_addr;
            assign xl_hi[w]   = '0;
        end
    end

    always_comb begin
        sel_hit     = 1'b0;
        sel_win     = '0;
        sel_tgt     = '0;
        sel_attr    = '0;
        sel_addr    = lk_addr;
        sel_addr_hi = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (grant[w]) begin
                sel_hit     = 1'b1;
                sel_win     = WIN_W'(w);
                sel_tgt     = win_tgt[w];
                sel_attr    = win_attr[w];
                sel_addr    = xl_addr[w];
                sel_addr_hi = xl_hi[w];
            end
        end
    end

    // R6: at most one window granted, and one whenever any matches
    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|grant) == (|match)));
endmodule

// File: rtl/awd_decoder.sv
`timescale 1ns/1ps
module awd_decoder
    import awd_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NREMAP = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int RA_W  = WIN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [AWD_DW-1:0]  reg_wdata,
    output logic [AWD_DW-1:0]  reg_rdata,
    input  logic               lk_valid,
    input  logic [AWD_DW-1:0]  lk_addr,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic [WIN_W-1:0]   res_win,
    output logic [AWD_TGW-1:0] res_target,
    output logic [AWD_ATW-1:0] res_attr,
    output logic [AWD_DW-1:0]  res_addr,
    output logic [AWD_DW-1:0]  res_addr_hi
);
    logic [NWIN-1:0]                win_en;
    logic [NWIN-1:0][AWD_TGW-1:0]   win_tgt;
    logic [NWIN-1:0][AWD_ATW-1:0]   win_attr;
    logic [NWIN-1:0][AWD_SZW-1:0]   win_size;
    logic [NWIN-1:0][AWD_SZW-1:0]   win_base;
    logic [NREMAP-1:0][AWD_SZW-1:0] rmp_lo;
    logic [NREMAP-1:0][AWD_DW-1:0]  rmp_hi;
    logic [NWIN-1:0]                match;

    logic                           sel_hit;
    logic [WIN_W-1:0]               sel_win;
    logic [AWD_TGW-1:0]             sel_tgt;
    logic [AWD_ATW-1:0]             sel_attr;
    logic [AWD_DW-1:0]              sel_addr;
    logic [AWD_DW-1:0]              sel_addr_hi;

    awd_regfile #(.NWIN(NWIN), .NREMAP(NREMAP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_en    (win_en),
        .win_tgt   (win_tgt),
        .win_attr  (win_attr),
        .win_size  (win_size),
        .win_base  (win_base),
        .rmp_lo    (rmp_lo),
        .rmp_hi    (rmp_hi)
    );

    awd_match #(.NWIN(NWIN)) u_match (
        .win_en   (win_en),
        .win_size (win_size),
        .win_base (win_base),
        .lk_page  (lk_addr[AWD_PGW +: AWD_SZW]),
        .match    (match)
    );

    awd_select #(.NWIN(NWIN), .NREMAP(NREMAP)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (match),
        .win_tgt     (win_tgt),
        .win_attr    (win_attr),
        .win_size    (win_size),
        .rmp_lo      (rmp_lo),
        .rmp_hi      (rmp_hi),
        .lk_addr     (lk_addr),
        .sel_hit     (sel_hit),
        .sel_win     (sel_win),
        .sel_tgt     (sel_tgt),
        .sel_attr    (sel_attr),
        .sel_addr    (sel_addr),
        .sel_addr_hi (sel_addr_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_miss    <= 1'b0;
            res_win     <= '0;
            res_target  <= '0;
            res_attr    <= '0;
            res_addr    <= '0;
            res_addr_hi <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && sel_hit;
            res_miss  <= lk_valid && !sel_hit;
            if (lk_valid) begin
                res_win     <= sel_win;
                res_target  <= sel_tgt;
                res_attr    <= sel_attr;
                res_addr    <= sel_addr;
                res_addr_hi <= sel_addr_hi;
            end
        end
    end

    // R11: one outcome per result, none when idle
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid ? (res_hit ^ res_miss) : (!res_hit && !res_miss));

    // R10: result appears exactly one cycle after the request
    assert_result_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R7: a miss leaves the address untouched and the fields clear
    assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_addr == $past(lk_addr) && res_win == '0 &&
                                     res_target == '0 && res_attr == '0 && res_addr_hi == '0));

    // R9: plain windows never translate
    assert_flat_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && (int'(res_win) >= NREMAP)) |->
            (res_addr == $past(lk_addr) && res_addr_hi == '0));
endmodule

// File: tb/sim_awd_decoder.sv
`timescale 1ns/1ps
module sim_awd_decoder;
    localparam int NWIN   = 8;
    localparam int NREMAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [2:0]  res_win;
    logic [3:0]  res_target;
    logic [7:0]  res_attr;
    logic [31:0] res_addr, res_addr_hi;

    always #2 clk = ~clk;

    awd_decoder #(.NWIN(NWIN), .NREMAP(NREMAP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win),
        .res_target(res_target), .res_attr(res_attr), .res_addr(res_addr),
        .res_addr_hi(res_addr_hi)
    );

    typedef struct {
        string       tag;
        logic        hit;
        logic [2:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] a;
        logic [31:0] ahi;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          failures = 0;
    logic [31:0] m_ctrl[NWIN];
    logic [31:0] m_base[NWIN];
    logic [31:0] m_rlo[NWIN];
    logic [31:0] m_rhi[NWIN];

    function automatic logic [31:0] mkctrl(input logic [15:0] sz, input logic [7:0] at,
                                           input logic [3:0] tg, input logic en);
        return {sz, at, tg, 3'b000, en};
    endfunction

    function automatic exp_t predict(input logic [31:0] a, input string tag);
        exp_t e;
        e.tag = tag; e.hit = 1'b0; e.win = '0; e.tgt = '0; e.attr = '0; e.a = a; e.ahi = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            logic [15:0] sz;
            sz = m_ctrl[w][31:16];
            if (m_ctrl[w][0] && ((a[31:16] & ~sz) == (m_base[w][31:16] & ~sz))) begin
                e.hit  = 1'b1;
                e.win  = 3'(w);
                e.tgt  = m_ctrl[w][7:4];
                e.attr = m_ctrl[w][15:8];
                if (w < NREMAP) begin
                    e.a   = {(m_rlo[w][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
                    e.ahi = m_rhi[w];
                end else begin
                    e.a   = a;
                    e.ahi = '0;
                end
            end
        end
        return e;
    endfunction

    function automatic void model_write(input int w, input int sel, input logic [31:0] d);
        case (sel)
            0: m_ctrl[w] = d;
            1: m_base[w] = d;
            2: if (w < NREMAP) m_rlo[w] = d;
            default: if (w < NREMAP) m_rhi[w] = d;
        endcase
    endfunction

    task automatic reg_write(input int w, input int sel, input logic [31:0] d);
        @(negedge clk);
        lk_valid = 1'b0; reg_rd = 1'b0;
        reg_wr = 1'b1; reg_addr = {w[2:0], sel[1:0]}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(w, sel, d);
    endtask

    task automatic reg_check(input int w, input int sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        lk_valid = 1'b0; reg_wr = 1'b0;
        reg_rd = 1'b1; reg_addr = {w[2:0], sel[1:0]};
        @(negedge clk);
        reg_rd = 1'b0;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s: reg w%0d sel%0d actual=%h expected=%h", tag, w, sel, reg_rdata, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a, input string tag);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        lk_valid = 1'b1; lk_addr = a;
        sbq.push_back(predict(a, tag));
    endtask

    task automatic lookup_with_write(input logic [31:0] a, input int w, input int sel,
                                     input logic [31:0] d, input string tag);
        @(negedge clk);
        reg_rd = 1'b0;
        sbq.push_back(predict(a, tag));
        lk_valid = 1'b1; lk_addr = a;
        reg_wr = 1'b1; reg_addr = {w[2:0], sel[1:0]}; reg_wdata = d;
        @(negedge clk);
        lk_valid = 1'b0; reg_wr = 1'b0;
        model_write(w, sel, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lk_valid = 1'b0;
        end
    endtask

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sbq.size() == 0) begin
                failures++;
                $display("FAIL R10: result with no request actual=1 expected=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (res_hit !== e.hit || res_miss !== !e.hit || res_win !== e.win ||
                    res_target !== e.tgt || res_attr !== e.attr ||
                    res_addr !== e.a || res_addr_hi !== e.ahi) begin
                    failures++;
                    $display("FAIL %s: actual hit=%b miss=%b win=%0d tgt=%h attr=%h addr=%h hi=%h expected hit=%b win=%0d tgt=%h attr=%h addr=%h hi=%h",
                             e.tag, res_hit, res_miss, res_win, res_target, res_attr,
                             res_addr, res_addr_hi, e.hit, e.win, e.tgt, e.attr, e.a, e.ahi);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int w = 0; w < NWIN; w++) begin
            m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_check(7, 0, 32'h0, "R1");
        reg_check(0, 1, 32'h0, "R1");
        reg_check(2, 3, 32'h0, "R1");
        lookup(32'h9000_0000, "R1");
        idle(2);

        // program windows
        reg_write(0, 0, mkctrl(16'h0FFF, 8'hE8, 4'h4, 1'b1));
        reg_write(0, 1, 32'h9000_0000);
        reg_write(0, 2, 32'h4000_0000);
        reg_write(0, 3, 32'h0000_0007);
        reg_write(1, 0, mkctrl(16'h0000, 8'h2F, 4'h4, 1'b1));
        reg_write(1, 1, 32'hC000_0000);
        reg_write(1, 2, 32'h5555_0000);
        reg_write(2, 0, mkctrl(16'h07FF, 8'hD8, 4'h1, 1'b1));
        reg_write(2, 1, 32'hD800_0000);
        reg_write(2, 2, 32'hD800_0000);
        reg_write(3, 0, mkctrl(16'h00FF, 8'h11, 4'h2, 1'b1));
        reg_write(3, 1, 32'h9000_0000);
        reg_write(3, 2, 32'h2100_0000);
        reg_write(3, 3, 32'h0000_0001);
        reg_write(4, 0, mkctrl(16'h00FF, 8'h0F, 4'h1, 1'b1));
        reg_write(4, 1, 32'hF800_0000);
        reg_write(4, 2, 32'h1234_0000);
        reg_write(5, 0, mkctrl(16'h0000, 8'h01, 4'h3, 1'b1));
        reg_write(5, 1, 32'hF900_0000);
        reg_write(5, 3, 32'hABCD_0000);
        reg_write(6, 0, mkctrl(16'hFFFF, 8'h55, 4'h7, 1'b0));
        reg_write(7, 1, 32'hB000_0000);

        // R2: readback of full words
        reg_check(0, 0, mkctrl(16'h0FFF, 8'hE8, 4'h4, 1'b1), "R2");
        reg_check(2, 1, 32'hD800_0000, "R2");
        reg_check(3, 2, 32'h2100_0000, "R2");
        reg_check(0, 3, 32'h0000_0007, "R2");

        // R3: plain windows have no remap storage
        reg_check(4, 2, 32'h0, "R3");
        reg_check(5, 3, 32'h0, "R3");

        // back-to-back lookups
        lookup(32'h9123_4567, "R8");
        lookup(32'h9012_3456, "R6");
        lookup(32'hC000_FFFF, "R4");
        lookup(32'hC001_0000, "R7");
        lookup(32'hBFFF_FFFF, "R4");
        lookup(32'hDFFF_0001, "R8");
        lookup(32'hF8FF_FFFF, "R9");
        lookup(32'hF900_8000, "R9");
        lookup(32'hF7FF_FFFF, "R4");
        lookup(32'hA000_1234, "R5");
        idle(2);

        // R5 / R6: disable window 0, overlap falls to window 3
        reg_write(0, 0, mkctrl(16'h0FFF, 8'hE8, 4'h4, 1'b0));
        lookup(32'h9012_3456, "R6");
        lookup(32'h9123_4567, "R5");
        idle(2);

        // R10: write in the lookup's own cycle is not seen
        lookup_with_write(32'hB000_0010, 7, 0, mkctrl(16'h0000, 8'h77, 4'h6, 1'b1), "R10");
        lookup(32'hB000_0010, "R9");
        idle(3);

        // R10: no result while idle
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R10: idle res_valid actual=%b expected=0", res_valid);
        end

        // R11 covered per result; all requests answered
        checks++;
        if (sbq.size() != 0) begin
            failures++;
            $display("FAIL R11: unanswered requests actual=%0d expected=0", sbq.size());
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule